// File: doc/BRIEF.md
# Microwire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM made of 16-bit words. It sits on a four-pin serial link: select, serial clock, data in and data out. A host frames each command while select is high. The frame starts with a 1 bit, followed by a two-bit operation code and an address. Commands that carry data then take a 16-bit word. The model covers single-word read, write and erase, whole-array erase and fill, and the write-enable and write-disable commands. The storage is an internal register file that comes out of reset holding all ones.

All pins are sampled by the system clock, so the serial clock must be much slower than the system clock. A rising serial clock edge is detected from its registered copies. After any program operation the device stays busy for `BUSY_CYC` system clocks. The host drops select and raises it again, then polls data out: it reads 0 while the device is busy and 1 once the operation has finished. The address width is a parameter: 6 for small parts, 8 for large ones.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset, data out is 0, every word reads 0xFFFF and programming is disabled.
- R2: While select is high, 0 bits before the start bit are ignored. The start bit (1) is followed by a two-bit opcode and then `ADDR_W` address bits, all taken MSB first on rising serial clock edges.
- R3: Opcode 2'b10 reads a word. Data out first shows one 0 bit, then the addressed word MSB first. Each following rising serial clock edge advances the output by one bit.
- R4: Opcode 2'b01 takes 16 data bits MSB first after the address and stores them in the addressed word.
- R5: Opcode 2'b11 sets the addressed word to 0xFFFF.
- R6: Opcode 2'b00 uses the two address MSBs as a sub-code: 2'b11 enables programming and 2'b00 disables it. The lower address bits are don't-care.
- R7: Opcode 2'b00 with sub-code 2'b10 sets every word to 0xFFFF. Sub-code 2'b01 takes 16 data bits and writes them to every word.
- R8: Write, erase, erase-all and write-all leave the array unchanged unless programming is enabled. A refused command starts no busy period: after select is toggled, data out stays 0.
- R9: After an accepted program command and a select toggle, data out is 0 while busy and 1 afterwards. A start bit sent while busy is ignored.
- R10: Dropping select mid-frame abandons the command with no effect. The device returns to waiting for a start bit.
- R11: Data out is 0 whenever select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low synchronous reset |
| csel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, much slower than clk |
| dIn | input | 1 | Serial data into the device |
| dOut | output | 1 | Serial data out: read bits or ready status |

## Verification
The hardest case to reach from the ports is a start bit that arrives while the device is busy. It has to be rejected silently. The device must then still show ready status once the busy period ends, without taking the bit as the start of a frame. The bench sets a busy period longer than one serial bit and clocks a lone 1 into a freshly reselected device. It then checks that data out moves from 0 to 1 while select stays high. Random command streams from a fixed seed run against a bench-side word array and enable flag, and they often reach programming while disabled.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } mwOp_e;

  typedef enum logic [1:0] {
    SUB_LOCK    = 2'b00,
    SUB_FILLALL = 2'b01,
    SUB_CLRALL  = 2'b10,
    SUB_UNLOCK  = 2'b11
  } mwSub_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DEC, ST_DAT, ST_PRG, ST_RD, ST_HOLD
  } mwState_e;

  typedef struct packed {
    logic shiftOp;
    logic shiftAddr;
    logic shiftData;
    logic loadRead;
    logic shiftOut;
    logic wrWord;
    logic eraseWord;
    logic wrAll;
    logic eraseAll;
  } mwStrobe_t;

  localparam int WORD_W = 16;

endpackage

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  mwStrobe_t         strb,
  output logic [1:0]        opCode,
  output logic [ADDR_W-1:0] addrVal,
  output logic              outBit
);
  localparam int WORDS = 1 << ADDR_W;

  logic [1:0]        opReg;
  logic [ADDR_W-1:0] addrReg;
  logic [WORD_W-1:0] dataReg;
  logic [WORD_W:0]   outReg;
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      addrReg <= '0;
      dataReg <= '0;
      outReg  <= '0;
    end else begin
      if (strb.shiftOp)   opReg   <= {opReg[0], bitIn};
      if (strb.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], bitIn};
      if (strb.shiftData) dataReg <= {dataReg[WORD_W-2:0], bitIn};
      if (strb.loadRead)      outReg <= {1'b0, mem[addrReg]};
      else if (strb.shiftOut) outReg <= {outReg[WORD_W-1:0], 1'b0};
    end
  end

  // Storage array: one register per word, reset to all ones.
  genvar gi;
  generate
    for (gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rstN) begin
          mem[gi] <= '1;
        end else if (strb.eraseAll) begin
          mem[gi] <= '1;
        end else if (strb.wrAll) begin
          mem[gi] <= dataReg;
        end else if (strb.eraseWord && (addrReg == ADDR_W'(gi))) begin
          mem[gi] <= '1;
        end else if (strb.wrWord && (addrReg == ADDR_W'(gi))) begin
          mem[gi] <= dataReg;
        end
      end
    end
  endgenerate

  assign opCode  = opReg;
  assign addrVal = addrReg;
  assign outBit  = outReg[WORD_W];

  AST_DUMMY_LEAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRead |=> !outBit) else $error("dummy bit not zero"); // R3
  AST_ERASE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    strb.eraseWord |=> (mem[addrReg] == '1)) else $error("erase left zeros"); // R5
  AST_FILL_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAll |=> (mem[0] == $past(dataReg))) else $error("fill missed word 0"); // R7

endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csel,
  input  logic              sclk,
  input  logic              dIn,
  input  logic [1:0]        opCode,
  input  logic [ADDR_W-1:0] addrVal,
  input  logic              outBit,
  output logic              bitIn,
  output mwStrobe_t         strb,
  output logic              dOut
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic cselQ, sclkQ, sclkQQ, dInQ;
  logic rise;
  mwState_e state;
  logic [CNT_W-1:0]  bitCnt;
  logic [BUSY_W-1:0] busyCnt;
  logic busy, wrEn, statusFlag, commit;
  logic [1:0] subCode;

  assign rise    = sclkQ && !sclkQQ;
  assign busy    = (busyCnt != '0);
  assign subCode = addrVal[ADDR_W-1 -: 2];
  assign bitIn   = dInQ;

  // Program commands that actually modify the array.
  always_comb begin
    commit = 1'b0;
    if (cselQ && wrEn) begin
      if (state == ST_DEC)
        commit = (opCode == OP_ERASE) ||
                 (opCode == OP_SPECIAL && subCode == SUB_CLRALL);
      else if (state == ST_PRG)
        commit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cselQ  <= 1'b0;
      sclkQ  <= 1'b0;
      sclkQQ <= 1'b0;
      dInQ   <= 1'b0;
    end else begin
      cselQ  <= csel;
      sclkQ  <= sclk;
      sclkQQ <= sclkQ;
      dInQ   <= dIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      busyCnt    <= '0;
      wrEn       <= 1'b0;
      statusFlag <= 1'b0;
    end else begin
      if (commit) begin
        busyCnt    <= BUSY_W'(BUSY_CYC);
        statusFlag <= 1'b1;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end

      if (!cselQ) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: if (rise && dInQ && !busy) begin
            state      <= ST_OPC;
            bitCnt     <= '0;
            statusFlag <= 1'b0;
          end
          ST_OPC: if (rise) begin
            if (bitCnt == CNT_W'(1)) begin
              state  <= ST_ADR;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_ADR: if (rise) begin
            if (bitCnt == CNT_W'(ADDR_W - 1)) begin
              state  <= ST_DEC;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_DEC: begin
            unique case (opCode)
              OP_READ:  state <= ST_RD;
              OP_WRITE: state <= ST_DAT;
              OP_ERASE: state <= ST_HOLD;
              default: begin
                if (subCode == SUB_FILLALL) state <= ST_DAT;
                else                        state <= ST_HOLD;
                if (subCode == SUB_UNLOCK) wrEn <= 1'b1;
                if (subCode == SUB_LOCK)   wrEn <= 1'b0;
              end
            endcase
          end
          ST_DAT: if (rise) begin
            if (bitCnt == CNT_W'(WORD_W - 1)) begin
              state  <= ST_PRG;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_PRG:  state <= ST_HOLD;
          ST_RD:   state <= ST_RD;
          default: state <= ST_HOLD;
        endcase
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.shiftOp   = cselQ && rise && (state == ST_OPC);
    strb.shiftAddr = cselQ && rise && (state == ST_ADR);
    strb.shiftData = cselQ && rise && (state == ST_DAT);
    strb.shiftOut  = cselQ && rise && (state == ST_RD);
    strb.loadRead  = cselQ && (state == ST_DEC) && (opCode == OP_READ);
    strb.eraseWord = commit && (state == ST_DEC) && (opCode == OP_ERASE);
    strb.eraseAll  = commit && (state == ST_DEC) && (opCode == OP_SPECIAL);
    strb.wrWord    = commit && (state == ST_PRG) && (opCode == OP_WRITE);
    strb.wrAll     = commit && (state == ST_PRG) && (opCode == OP_SPECIAL);
  end

  always_comb begin
    dOut = 1'b0;
    if (cselQ) begin
      if (state == ST_RD)                       dOut = outBit;
      else if (state == ST_IDLE && statusFlag)  dOut = !busy;
    end
  end

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cselQ |=> (state == ST_IDLE)) else $error("frame survived deselect"); // R10
  AST_PROG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> wrEn) else $error("busy while locked"); // R8
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE)) else $error("start taken while busy"); // R9
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cselQ |-> !dOut) else $error("dOut driven while deselected"); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.shiftOp, strb.shiftAddr, strb.shiftData, strb.shiftOut,
              strb.loadRead, strb.wrWord, strb.eraseWord, strb.wrAll, strb.eraseAll}))
    else $error("strobes overlap"); // R2

endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic csel,
  input  logic sclk,
  input  logic dIn,
  output logic dOut
);
  mwStrobe_t         strb;
  logic [1:0]        opCode;
  logic [ADDR_W-1:0] addrVal;
  logic              outBit;
  logic              bitIn;

  mw_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .dIn(dIn),
    .opCode(opCode), .addrVal(addrVal), .outBit(outBit),
    .bitIn(bitIn), .strb(strb), .dOut(dOut)
  );

  mw_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .strb(strb),
    .opCode(opCode), .addrVal(addrVal), .outBit(outBit)
  );

endmodule

// File: tb/sim_mw_eeprom_model.sv
module sim_mw_eeprom_model;
  localparam int AW   = 6;
  localparam int BUSY = 300;
  localparam int HALF = 6;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, csel = 1'b0, sclk = 1'b0, dIn = 1'b0;
  logic dOut;
  int nVec = 0, nBad = 0;
  logic [15:0] refMem [NW];
  logic refEn = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom_model #(.ADDR_W(AW), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rstN(rstN), .csel(csel), .sclk(sclk), .dIn(dIn), .dOut(dOut));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitOut(input logic b);
    dIn = b; sclk = 1'b0; waitClk(HALF);
    sclk = 1'b1; waitClk(HALF);
  endtask

  task automatic deselect();
    sclk = 1'b0; dIn = 1'b0; csel = 1'b0; waitClk(HALF);
  endtask

  task automatic sendHdr(input logic [1:0] op, input logic [AW-1:0] a, input int lead);
    csel = 1'b1; waitClk(2);
    for (int i = 0; i < lead; i++) bitOut(1'b0);
    bitOut(1'b1); bitOut(op[1]); bitOut(op[0]);
    for (int i = AW - 1; i >= 0; i--) bitOut(a[i]);
  endtask

  task automatic readWord(input logic [AW-1:0] a, input int lead,
                          output logic [15:0] w, output logic dummy);
    sendHdr(2'b10, a, lead);
    waitClk(2);
    dummy = dOut;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; waitClk(HALF);
      sclk = 1'b1; waitClk(HALF);
      w = {w[14:0], dOut};
    end
    deselect();
  endtask

  task automatic checkRead(input logic [AW-1:0] a, input string tag);
    logic [15:0] w; logic dm;
    readWord(a, 0, w, dm);
    chk({15'd0, dm}, 16'd0, {tag, " dummy"});
    chk(w, refMem[a], tag);
  endtask

  // Reselect and observe status: busy 0 then ready 1, or quiet 0 when nothing ran.
  task automatic checkStatus(input logic expectBusy, input string tag);
    int n;
    csel = 1'b1; waitClk(3);
    if (expectBusy) begin
      chk({15'd0, dOut}, 16'd0, {tag, " busy"});
      n = 0;
      while (dOut !== 1'b1 && n < BUSY + 40) begin waitClk(1); n++; end
      chk({15'd0, dOut}, 16'd1, {tag, " ready"});
    end else begin
      waitClk(BUSY + 20);
      chk({15'd0, dOut}, 16'd0, {tag, " no status"});
    end
    deselect();
  endtask

  // Program command; sub selects special code through the address MSBs.
  task automatic prog(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [15:0] d, input string tag);
    logic hasData, isProg;
    hasData = (op == 2'b01) || (op == 2'b00 && a[AW-1 -: 2] == 2'b01);
    isProg  = (op != 2'b00) || (a[AW-1 -: 2] == 2'b01) || (a[AW-1 -: 2] == 2'b10);
    sendHdr(op, a, 0);
    if (hasData) for (int i = 15; i >= 0; i--) bitOut(d[i]);
    deselect();
    if (isProg && refEn) begin
      if (op == 2'b01) refMem[a] = d;
      else if (op == 2'b11) refMem[a] = 16'hFFFF;
      else for (int k = 0; k < NW; k++) refMem[k] = (a[AW-1 -: 2] == 2'b10) ? 16'hFFFF : d;
    end
    if (op == 2'b00 && a[AW-1 -: 2] == 2'b11) refEn = 1'b1;
    if (op == 2'b00 && a[AW-1 -: 2] == 2'b00) refEn = 1'b0;
    checkStatus(isProg && refEn, tag);
  endtask

  initial begin
    waitClk(200000);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w; logic dm;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < NW; k++) refMem[k] = 16'hFFFF;
    waitClk(5); rstN = 1'b1; waitClk(3);

    chk({15'd0, dOut}, 16'd0, "R1 reset dOut");
    checkRead(6'd0,  "R1 reset word 0");
    checkRead(6'd63, "R1 reset word 63");
    prog(2'b01, 6'd5, 16'h1234, "R1 locked at reset");
    checkRead(6'd5, "R8 locked write ignored");

    prog(2'b00, 6'b110101, 16'h0, "R6 unlock with dont-care bits");
    prog(2'b01, 6'd5, 16'hA5C3, "R4 write");
    checkRead(6'd5, "R4 readback");
    readWord(6'd5, 3, w, dm);
    chk(w, 16'hA5C3, "R2 leading zeros ignored");
    chk({15'd0, dm}, 16'd0, "R3 dummy after zeros");
    prog(2'b11, 6'd5, 16'h0, "R5 erase");
    checkRead(6'd5, "R5 word all ones");

    // R10: abort a write after half its data bits
    sendHdr(2'b01, 6'd9, 0);
    for (int i = 0; i < 8; i++) bitOut(1'b0);
    deselect();
    checkStatus(1'b0, "R10 aborted");
    checkRead(6'd9, "R10 word untouched");

    // R9: start bit while busy is ignored
    sendHdr(2'b01, 6'd9, 0);
    for (int i = 15; i >= 0; i--) bitOut(1'b0);
    deselect();
    refMem[9] = 16'h0000;
    csel = 1'b1; waitClk(3);
    chk({15'd0, dOut}, 16'd0, "R9 busy low");
    bitOut(1'b1); sclk = 1'b0;
    waitClk(BUSY);
    chk({15'd0, dOut}, 16'd1, "R9 start ignored, ready shown");
    deselect();
    chk({15'd0, dOut}, 16'd0, "R11 quiet when deselected");
    checkRead(6'd9, "R9 written word");

    prog(2'b00, 6'b010000, 16'h5AF0, "R7 fill all");
    checkRead(6'd0,  "R7 fill word 0");
    checkRead(6'd40, "R7 fill word 40");
    prog(2'b00, 6'b100011, 16'h0, "R7 clear all");
    checkRead(6'd40, "R7 clear word 40");

    prog(2'b00, 6'b000111, 16'h0, "R6 lock");
    prog(2'b01, 6'd3, 16'h0F0F, "R8 locked write");
    prog(2'b00, 6'b100000, 16'h0, "R8 locked clear");
    checkRead(6'd3, "R8 word unchanged");

    // Random stream against the bench array
    for (int n = 0; n < 30; n++) begin
      int unsigned pick;
      logic [AW-1:0] a;
      logic [15:0] d;
      pick = $urandom % 10;
      a = AW'($urandom);
      d = 16'($urandom);
      case (pick)
        0, 1, 2: checkRead(a, "R3 random read");
        3, 4:    prog(2'b01, a, d, "R4 random write");
        5:       prog(2'b11, a, d, "R5 random erase");
        6, 7:    prog(2'b00, {2'b11, a[AW-3:0]}, d, "R6 random unlock");
        8:       prog(2'b00, {2'b00, a[AW-3:0]}, d, "R8 random lock");
        default: prog(2'b00, {2'b01, a[AW-3:0]}, d, "R7 random fill");
      endcase
    end
    checkRead(6'd17, "R4 final read");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule